// File: doc/BRIEF.md
# LIN Frame Checksum Unit

This block computes the checksum of a LIN frame as its bytes stream past, and checks the checksum of a received frame. A start pulse opens a frame, clears the running sum and fixes the coverage mode for that frame. The mode is either classic, where only data bytes count, or enhanced, where the protected identifier byte counts as well. Bytes then arrive one per clock under a valid strobe. A side flag marks the identifier byte. An end strobe closes the frame.

The running sum uses 8-bit addition with end-around carry. When a partial sum reaches 256 or more, 255 is taken off it. On the end strobe the unit registers the inverted sum as the checksum byte to transmit. When the end strobe also flags a received checksum, the byte on the data input in that cycle is added to the uninverted sum, and the frame passes only if the result equals 0xFF. Frame parsing, bit timing and identifier parity are handled elsewhere.

Top module: `lin_cks_top`

## Requirements
- R1: After reset, `done_o`, `pass_o` and `chk_o` are all zero.
- R2: A `start_i` pulse sets the running sum to zero and latches `enh_i` as the frame mode (1 = enhanced, 0 = classic). `enh_i` has no effect in any other cycle.
- R3: Each accepted byte is added with end-around carry: if sum + byte >= 256, the new sum is sum + byte - 255. For example, 0xF0 then 0x20 gives 0x11, and 0xFF then 0x01 gives 0x01.
- R4: In the cycle after `end_i`, `done_o` is high for exactly one cycle and `chk_o` holds the bitwise inverse of the running sum. `chk_o` and `pass_o` keep their values until the next end strobe.
- R5: In classic mode, a byte with `pid_i` high is not added to the sum.
- R6: In enhanced mode, the identifier byte is added to the sum. Identifier 0xEC with data 0x01, 0x02 gives checksum 0x10. Identifier 0xAD with data 0x01, 0x02, 0x03 gives checksum 0x4C.
- R7: When `end_i` and `rxchk_i` are both high, `pass_o` becomes 1 if the end-around sum of the running sum and `byte_i` equals 0xFF, and 0 otherwise. With `rxchk_i` low at the end strobe, `pass_o` becomes 0.
- R8: At most MAX_BYTES bytes (default 9, counting the identifier in enhanced mode) are added per frame. Any later valid byte leaves the sum unchanged.
- R9: A byte presented in the same cycle as `start_i` is not added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start pulse |
| enh_i | input | 1 | Mode sampled at start: 1 enhanced, 0 classic |
| vld_i | input | 1 | Byte valid strobe |
| pid_i | input | 1 | Marks the current byte as the identifier |
| byte_i | input | 8 | Frame byte, or received checksum at the end strobe |
| end_i | input | 1 | Frame end strobe |
| rxchk_i | input | 1 | At the end strobe, byte_i carries a received checksum to verify |
| chk_o | output | 8 | Registered checksum to transmit |
| pass_o | output | 1 | Registered receive check result |
| done_o | output | 1 | One-cycle pulse when results update |

## Verification
On every cycle the assertions check the following: the sum is zero after a start, the mode holds between starts, the byte count stays at or below its limit, and a byte past that limit or a classic-mode identifier byte leaves the sum unchanged. They also check that `done_o` only follows an end strobe. The exact checksum values, the carry wrap at 0xFF/0x100, and the 0xFF pass test for matching and corrupted received bytes are only shown by the bench's frames, which compare the outputs against a behavioural model on every clock.

// File: rtl/lin_cks_pkg.sv
package lin_cks_pkg;
  typedef enum logic {MODE_CLASSIC = 1'b0, MODE_ENHANCED = 1'b1} cks_mode_t;

  // 8-bit add with end-around carry
  function automatic logic [7:0] ea_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction
endpackage

// File: rtl/lin_cks_ctrl.sv
module lin_cks_ctrl
  import lin_cks_pkg::*;
#(
  parameter int MAX_BYTES = 9,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          enh_i,
  input  logic          vld_i,
  input  logic          pid_i,
  output cks_mode_t     mode_o,
  output logic          take_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = CW'(MAX_BYTES);

  cks_mode_t     mode_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    take_o = vld_i && !start_i && (cnt_q < CMAX) &&
             (!pid_i || mode_q == MODE_ENHANCED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CLASSIC;
      cnt_q  <= '0;
    end else if (start_i) begin
      mode_q <= enh_i ? MODE_ENHANCED : MODE_CLASSIC;
      cnt_q  <= '0;
    end else if (take_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(mode_q));
  p_cnt_limit_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CMAX);
  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> cnt_q == '0);
endmodule

// File: rtl/lin_cks_acc.sv
module lin_cks_acc
  import lin_cks_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         add_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) sum_q <= '0;
    else if (add_i)   sum_q <= ea_add(sum_q, byte_i);
  end

  assign sum_o = sum_q;

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> sum_q == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !add_i) |=> $stable(sum_q));
endmodule

// File: rtl/lin_cks_top.sv
module lin_cks_top
  import lin_cks_pkg::*;
#(
  parameter int MAX_BYTES = 9,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       enh_i,
  input  logic       vld_i,
  input  logic       pid_i,
  input  logic [7:0] byte_i,
  input  logic       end_i,
  input  logic       rxchk_i,
  output logic [7:0] chk_o,
  output logic       pass_o,
  output logic       done_o
);
  cks_mode_t     mode;
  logic          take;
  logic [CW-1:0] cnt;
  logic [7:0]    sum;

  lin_cks_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .enh_i(enh_i),
    .vld_i(vld_i && !end_i), .pid_i(pid_i),
    .mode_o(mode), .take_o(take), .cnt_o(cnt)
  );

  lin_cks_acc #(.W(8)) u_acc (
    .clk(clk), .rst(rst), .clr_i(start_i), .add_i(take),
    .byte_i(byte_i), .sum_o(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_o  <= '0;
      pass_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= end_i;
      if (end_i) begin
        chk_o  <= ~sum;
        pass_o <= rxchk_i && (ea_add(sum, byte_i) == 8'hFF);
      end
    end
  end

  p_done_src_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(end_i));
  p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !end_i |=> ($stable(chk_o) && $stable(pass_o)));
  p_classic_pid_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CLASSIC && pid_i && vld_i && !start_i) |=> $stable(sum));
  p_over_limit_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(MAX_BYTES) && !start_i) |=> $stable(sum));
endmodule

// File: tb/lin_cks_top_test.sv
module lin_cks_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 9;

  logic clk = 0, rst = 1;
  logic start_i = 0, enh_i = 0, vld_i = 0, pid_i = 0, end_i = 0, rxchk_i = 0;
  logic [7:0] byte_i = 0;
  logic [7:0] chk_o;
  logic pass_o, done_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  lin_cks_top #(.MAX_BYTES(MAXB)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .enh_i(enh_i), .vld_i(vld_i),
    .pid_i(pid_i), .byte_i(byte_i), .end_i(end_i), .rxchk_i(rxchk_i),
    .chk_o(chk_o), .pass_o(pass_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_sum = 0, m_n = 0;
  bit m_enh = 0;
  int m_chk = 0;
  bit m_pass = 0, m_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_sum = 0; m_n = 0; m_enh = 0; m_chk = 0; m_pass = 0; m_done = 0;
    end else begin
      m_done = end_i;
      if (end_i) begin
        int t;
        m_chk = 255 - m_sum;
        t = m_sum + byte_i;
        if (t > 255) t = t - 255;
        m_pass = rxchk_i && (t == 255);
      end
      if (start_i) begin
        m_sum = 0; m_n = 0; m_enh = enh_i;
      end else if (vld_i && !end_i && m_n < MAXB && (!pid_i || m_enh)) begin
        m_sum = m_sum + byte_i;
        if (m_sum > 255) m_sum = m_sum - 255;
        m_n++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R4 done", done_o, m_done);
      check("R3 chk", chk_o, m_chk);
      check("R7 pass", pass_o, m_pass);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    start_i = 0; vld_i = 0; pid_i = 0; end_i = 0; rxchk_i = 0;
  endtask

  task automatic begin_frame(input bit enh);
    start_i = 1; enh_i = enh; step(); enh_i = ~enh;
  endtask

  task automatic put(input logic [7:0] b, input bit pid);
    vld_i = 1; pid_i = pid; byte_i = b; step();
  endtask

  task automatic finish_frame(input bit rx, input logic [7:0] rb,
                              input string req, input int exp_chk, input int exp_pass);
    end_i = 1; rxchk_i = rx; byte_i = rb; step();
    @(negedge clk);
    check({req, " done"}, done_o, 1);
    check({req, " chk"}, chk_o, exp_chk);
    check({req, " pass"}, pass_o, exp_pass);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    check("R1 chk", chk_o, 0); check("R1 pass", pass_o, 0); check("R1 done", done_o, 0);
    @(posedge clk); #1; rst = 0;

    // R6 enhanced vectors
    begin_frame(1); put(8'hEC, 1); put(8'h01, 0); put(8'h02, 0);
    finish_frame(0, 8'h00, "R6a", 8'h10, 0);
    begin_frame(1); put(8'hAD, 1); put(8'h01, 0); put(8'h02, 0); put(8'h03, 0);
    finish_frame(0, 8'h00, "R6b", 8'h4C, 0);
    // R5 classic ignores pid; R2 enh_i toggled after start (enh_i = ~enh)
    begin_frame(0); put(8'hEC, 1); put(8'h01, 0); put(8'h02, 0);
    finish_frame(0, 8'h00, "R5", 8'hFC, 0);
    // R3 carry wrap: F0+20 = 11 -> chk EE; FF+01 = 01 -> FE
    begin_frame(0); put(8'hF0, 0); put(8'h20, 0);
    finish_frame(0, 8'h00, "R3a", 8'hEE, 0);
    begin_frame(0); put(8'hFF, 0); put(8'h01, 0);
    finish_frame(0, 8'h00, "R3b", 8'hFE, 0);
    // R7 receive good and bad
    begin_frame(1); put(8'hEC, 1); put(8'h01, 0); put(8'h02, 0);
    finish_frame(1, 8'h10, "R7good", 8'h10, 1);
    begin_frame(1); put(8'hAD, 1); put(8'h01, 0); put(8'h02, 0); put(8'h03, 0);
    finish_frame(1, 8'h4D, "R7bad", 8'h4C, 0);
    // R8 limit: 9 bytes of 0x10 = 0x90, 10th ignored -> chk 6F
    begin_frame(1);
    for (int i = 0; i < MAXB + 2; i++) put(8'h10, i == 0);
    finish_frame(0, 8'h00, "R8", 8'h6F, 0);
    // R9 byte with start ignored
    start_i = 1; enh_i = 0; vld_i = 1; byte_i = 8'h40; step();
    put(8'h05, 0);
    finish_frame(0, 8'h00, "R9", 8'hFA, 0);
    // R4 outputs hold after done
    repeat (3) step();
    @(negedge clk);
    check("R4 hold done", done_o, 0); check("R4 hold chk", chk_o, 8'hFA);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule